// File: doc/BRIEF.md
# Core countdown timer with prescale

This block is a word-addressed countdown timer with four 32-bit registers: control, period, scale and count. Software loads a count, selects a step size and sets the power and enable bits. From then on the count falls by the step on every clock. When the remaining count is no larger than one step, the timer expires. Expiry sets a sticky flag in the control register and raises the interrupt output for one clock.

After expiry the timer either reloads the count from the period register and keeps running, or parks the count at zero and stays idle. It leaves that idle state only when the enable condition is removed and then set again. The period and count registers can be written at any time. A write to the period also loads the count. A change of scale while running continues from the present count.

The register bus is a plain single-cycle write strobe with a byte address and a combinational read port. Reads of the count return its live value.

Top module: `core_timer`

## Requirements
- R1: After reset, all four registers read zero and `irq_o` is low.
- R2: Registers sit at byte offsets 0x0 control, 0x4 period, 0x8 scale and 0xC count. The control bits are: bit 0 power, bit 1 enable, bit 2 auto-reload, bit 3 expiry flag. Control bits 31:4 read as zero.
- R3: The count changes by itself only while power and enable are both 1. With either bit at 0 the count holds and no expiry occurs.
- R4: The step is scale[7:0] + 1, a value from 1 to 256. Scale bits 31:8 are stored and read back but do not affect the step. In each running clock that does not expire, the count drops by the step.
- R5: After a control write that turns the enable condition on with count C, expiry happens on the clock edge max(1, ceil(C / step)) edges later. That edge sets the flag, and `irq_o` is high for the following cycle.
- R6: With auto-reload set, expiry loads the count from the period and counting goes on. With period P, expiries repeat every max(1, ceil(P / step)) clocks, so a period of 0 gives an interrupt every clock.
- R7: With auto-reload clear, expiry sets the count to 0 and the timer stops. Later count writes do not restart it. It re-arms only when a control write turns the enable condition off and a later one turns it back on.
- R8: A period write also loads the written value into the count, on the same edge.
- R9: A count write is accepted while the timer is running.
- R10: A control write stores bits 3:0 exactly as written. Writing 0 to the flag clears it, and writing 1 sets it.
- R11: A scale write while running keeps the current count. The edge that carries the write still uses the old step, and later edges use the new step.
- R12: When a bus write to the count or period lands on the same edge as a timer update, the written value wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| we_i | input | 1 | Write strobe, one word per cycle |
| addr_i | input | 4 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Combinational read data for `addr_i` |
| irq_o | output | 1 | One-cycle expiry pulse |

## Verification
A wrong step or a wrong decrement shows up in the count readback one clock after the first running edge. It also shifts the interrupt edge away from ceil(C / step), and the arithmetic sweep over count and scale catches that directly. A lost stop state produces extra `irq_o` pulses within a few clocks of a one-shot expiry. A broken reload or a broken period mirror shows in the count read on the cycle just after the interrupt or just after the write.

// File: rtl/ctmr_pkg.sv
package ctmr_pkg;
  localparam int unsigned CTRL_W = 4;

  typedef struct packed {
    logic flag;
    logic reload;
    logic en;
    logic pwr;
  } ctrl_t;

  typedef enum logic [1:0] {
    REG_CTRL   = 2'd0,
    REG_PERIOD = 2'd1,
    REG_SCALE  = 2'd2,
    REG_COUNT  = 2'd3
  } reg_sel_e;

  localparam int unsigned NUM_REGS = 4;
endpackage

// File: rtl/ctmr_decode.sv
module ctmr_decode #(
  parameter int unsigned ADDR_W   = 4,
  parameter int unsigned NUM_REGS = 4
) (
  input  logic                we_i,
  input  logic [ADDR_W-1:0]   addr_i,
  output logic [NUM_REGS-1:0] hit_o,
  output logic [NUM_REGS-1:0] wr_o
);
  localparam int unsigned IDX_W = ADDR_W - 2;

  logic unused_lsb;
  assign unused_lsb = ^addr_i[1:0];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_hit
    assign hit_o[g] = (addr_i[ADDR_W-1:2] == IDX_W'(g));
    assign wr_o[g]  = we_i & hit_o[g];
  end
endmodule

// File: rtl/ctmr_regs.sv
module ctmr_regs
  import ctmr_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [NUM_REGS-1:0] hit_i,
  input  logic [NUM_REGS-1:0] wr_i,
  input  logic [DATA_W-1:0]   wdata_i,
  input  logic                expire_i,
  input  logic [DATA_W-1:0]   count_i,
  output ctrl_t               ctrl_o,
  output logic [DATA_W-1:0]   period_o,
  output logic [DATA_W-1:0]   scale_o,
  output logic [DATA_W-1:0]   rdata_o
);
  ctrl_t ctrl_q;
  logic [DATA_W-1:0] period_q, scale_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (wr_i[REG_CTRL]) begin
      ctrl_q <= ctrl_t'(wdata_i[CTRL_W-1:0]);
    end else if (expire_i) begin
      ctrl_q.flag <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
      scale_q  <= '0;
    end else begin
      if (wr_i[REG_PERIOD]) period_q <= wdata_i;
      if (wr_i[REG_SCALE])  scale_q  <= wdata_i;
    end
  end

  logic [DATA_W-1:0] view [NUM_REGS];
  assign view[REG_CTRL]   = {{(DATA_W-CTRL_W){1'b0}}, ctrl_q};
  assign view[REG_PERIOD] = period_q;
  assign view[REG_SCALE]  = scale_q;
  assign view[REG_COUNT]  = count_i;

  always_comb begin
    rdata_o = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (hit_i[i]) rdata_o = rdata_o | view[i];
    end
  end

  assign ctrl_o   = ctrl_q;
  assign period_o = period_q;
  assign scale_o  = scale_q;
endmodule

// File: rtl/ctmr_step.sv
module ctmr_step #(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned SCALE_W = 8
) (
  input  logic [SCALE_W-1:0] scale_i,
  input  logic [DATA_W-1:0]  count_i,
  output logic [DATA_W-1:0]  step_o,
  output logic               last_o
);
  localparam int unsigned STEP_W = SCALE_W + 1;

  logic [STEP_W-1:0] step_n;
  assign step_n = {1'b0, scale_i} + STEP_W'(1);
  assign step_o = {{(DATA_W-STEP_W){1'b0}}, step_n};
  // final (possibly partial) step
  assign last_o = (count_i <= step_o);
endmodule

// File: rtl/ctmr_core.sv
module ctmr_core #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enabled_i,
  input  logic              reload_i,
  input  logic              wr_count_i,
  input  logic              wr_period_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] period_i,
  input  logic [DATA_W-1:0] step_i,
  input  logic              last_i,
  output logic [DATA_W-1:0] count_o,
  output logic              run_o,
  output logic              expire_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] count_q, count_d;
  logic stop_q, irq_q;

  assign run_o    = enabled_i & ~stop_q;
  assign expire_o = run_o & last_i;

  always_comb begin
    count_d = count_q;
    if (wr_period_i || wr_count_i) begin
      count_d = wdata_i;
    end else if (expire_o) begin
      count_d = reload_i ? period_i : '0;
    end else if (run_o) begin
      count_d = count_q - step_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      count_q <= '0;
      stop_q  <= 1'b0;
      irq_q   <= 1'b0;
    end else begin
      count_q <= count_d;
      irq_q   <= expire_o;
      // idle after one-shot expiry; cleared once enable drops
      if (!enabled_i)                 stop_q <= 1'b0;
      else if (expire_o && !reload_i) stop_q <= 1'b1;
    end
  end

  assign count_o = count_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/core_timer.sv
module core_timer
  import ctmr_pkg::*;
#(
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 4,
  parameter int unsigned SCALE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              irq_o
);
  logic [NUM_REGS-1:0] hit, wr;
  ctrl_t               ctrl;
  logic [DATA_W-1:0]   period, scale, count, step;
  logic                last, run, expire, enabled;

  ctmr_decode #(.ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS)) u_decode (
    .we_i   (we_i),
    .addr_i (addr_i),
    .hit_o  (hit),
    .wr_o   (wr)
  );

  ctmr_regs #(.DATA_W(DATA_W)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .hit_i    (hit),
    .wr_i     (wr),
    .wdata_i  (wdata_i),
    .expire_i (expire),
    .count_i  (count),
    .ctrl_o   (ctrl),
    .period_o (period),
    .scale_o  (scale),
    .rdata_o  (rdata_o)
  );

  ctmr_step #(.DATA_W(DATA_W), .SCALE_W(SCALE_W)) u_step (
    .scale_i (scale[SCALE_W-1:0]),
    .count_i (count),
    .step_o  (step),
    .last_o  (last)
  );

  assign enabled = ctrl.pwr & ctrl.en;

  ctmr_core #(.DATA_W(DATA_W)) u_core (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enabled_i   (enabled),
    .reload_i    (ctrl.reload),
    .wr_count_i  (wr[REG_COUNT]),
    .wr_period_i (wr[REG_PERIOD]),
    .wdata_i     (wdata_i),
    .period_i    (period),
    .step_i      (step),
    .last_i      (last),
    .count_o     (count),
    .run_o       (run),
    .expire_o    (expire),
    .irq_o       (irq_o)
  );
endmodule

// File: rtl/core_timer_chk.sv
module core_timer_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              run,
  input logic              expire,
  input logic              reload,
  input logic              flag,
  input logic              wr_ctrl,
  input logic              wr_period,
  input logic              wr_count,
  input logic [DATA_W-1:0] count,
  input logic [DATA_W-1:0] period,
  input logic [DATA_W-1:0] step,
  input logic              irq_o
);
  // R3
  hold_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run && !wr_period && !wr_count) |=> (count == $past(count)));

  // R4
  step_decrement_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run && !expire && !wr_period && !wr_count) |=> (count == $past(count) - $past(step)));

  // R5
  irq_follows_expiry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    expire |=> irq_o);

  // R5
  flag_sticks_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && !wr_ctrl) |=> flag);

  // R6
  reload_from_period_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && reload && !wr_period && !wr_count) |=> (count == $past(period)));

  // R7
  oneshot_stop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (expire && !reload && !wr_ctrl && !wr_period && !wr_count) |=> (count == '0 && !run));

  // R8
  period_mirror_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_period |=> (count == period));
endmodule

bind core_timer core_timer_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .run       (run),
  .expire    (expire),
  .reload    (ctrl.reload),
  .flag      (ctrl.flag),
  .wr_ctrl   (wr[0]),
  .wr_period (wr[1]),
  .wr_count  (wr[3]),
  .count     (count),
  .period    (period),
  .step      (step),
  .irq_o     (irq_o)
);

// File: tb/core_timer_tb_top.sv
`timescale 1ns/1ps
module core_timer_tb_top;
  localparam logic [3:0] A_CTRL = 4'h0, A_PER = 4'h4, A_SCL = 4'h8, A_CNT = 4'hC;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  core_timer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%08h) expected %0d (0x%08h)", req, act, act, exp, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    we = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1;
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a;
    #1;
    d = rdata;
  endtask

  task automatic step_cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  // edges until irq is seen, counted from the last write edge
  task automatic wait_irq(output int n);
    n = 0;
    do begin
      @(posedge clk);
      n++;
      @(negedge clk);
    end while (!irq && n < 600);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int n, exp_n, step, extra;

    repeat (3) @(negedge clk);
    // R1 reset values
    for (int a = 0; a < 4; a++) begin
      rd(4'(a * 4), v);
      chk("R1 reg reset", v, 32'd0);
    end
    chk("R1 irq reset", {31'd0, irq}, 32'd0);
    rst_n = 1'b1;

    // R2 control upper bits read zero; R10 plain write sets/clears flag
    wr(A_CTRL, 32'hFFFF_FFF0);
    @(negedge clk); rd(A_CTRL, v); chk("R2 ctrl upper bits", v, 32'd0);
    wr(A_CTRL, 32'h8);
    @(negedge clk); rd(A_CTRL, v); chk("R10 flag write 1", v, 32'h8);
    wr(A_CTRL, 32'h0);
    @(negedge clk); rd(A_CTRL, v); chk("R10 flag write 0", v, 32'h0);

    // R4/R5/R7 sweep: one-shot expiry timing over count and scale
    for (int s = 0; s < 4; s++) begin
      for (int c = 0; c <= 12; c++) begin
        step = s + 1;
        exp_n = (c == 0) ? 1 : (c + step - 1) / step;
        wr(A_CTRL, 32'h0);
        wr(A_SCL, 32'(s));
        wr(A_CNT, 32'(c));
        wr(A_CTRL, 32'h3);
        n = 0;
        do begin
          @(posedge clk);
          n++;
          @(negedge clk);
          if (n == 1 && c > step) begin
            rd(A_CNT, v);
            chk("R4 first decrement", v, 32'(c - step));
          end
        end while (!irq && n < 600);
        chk("R5 expiry latency", 32'(n), 32'(exp_n));
        rd(A_CNT, v);  chk("R7 count parked", v, 32'd0);
        rd(A_CTRL, v); chk("R5 flag set", v, 32'hB);
        extra = 0;
        for (int k = 0; k < 5; k++) begin
          step_cycle();
          if (irq) extra++;
        end
        chk("R7 no further irq", 32'(extra), 32'd0);
      end
    end

    // R4 scale upper bits ignored, full step 256
    wr(A_CTRL, 32'h0);
    wr(A_SCL, 32'h0000_0203);
    wr(A_CNT, 32'd10);
    wr(A_CTRL, 32'h3);
    wait_irq(n);
    chk("R4 upper scale bits ignored", 32'(n), 32'd3);
    rd(A_SCL, v); chk("R4 scale readback", v, 32'h0000_0203);
    wr(A_CTRL, 32'h0);
    wr(A_SCL, 32'd255);
    wr(A_CNT, 32'd300);
    wr(A_CTRL, 32'h3);
    wait_irq(n);
    chk("R4 step 256 latency", 32'(n), 32'd2);

    // R7 count write after stop does not restart
    wr(A_CNT, 32'd5);
    extra = 0;
    for (int k = 0; k < 8; k++) begin
      step_cycle();
      if (irq) extra++;
    end
    chk("R7 stopped irq", 32'(extra), 32'd0);
    rd(A_CNT, v); chk("R7 stopped count", v, 32'd5);
    // R7 re-arm via enable off then on
    wr(A_CTRL, 32'h0);
    wr(A_SCL, 32'd0);
    wr(A_CTRL, 32'h3);
    wait_irq(n);
    chk("R7 re-arm latency", 32'(n), 32'd5);

    // R3 only power or only enable: no counting
    wr(A_CTRL, 32'h0);
    wr(A_CNT, 32'd10);
    wr(A_CTRL, 32'h1);
    extra = 0;
    for (int k = 0; k < 5; k++) begin step_cycle(); if (irq) extra++; end
    rd(A_CNT, v); chk("R3 power only holds", v, 32'd10);
    wr(A_CTRL, 32'h2);
    for (int k = 0; k < 5; k++) begin step_cycle(); if (irq) extra++; end
    rd(A_CNT, v); chk("R3 enable only holds", v, 32'd10);
    chk("R3 no irq when idle", 32'(extra), 32'd0);
    wr(A_CTRL, 32'h3);
    for (int k = 0; k < 3; k++) step_cycle();
    rd(A_CNT, v); chk("R3 counts when both set", v, 32'd7);

    // R8/R12 period write while running wins over decrement
    wr(A_CTRL, 32'h0);
    wr(A_CNT, 32'd100);
    wr(A_CTRL, 32'h3);
    wr(A_PER, 32'd50);
    @(negedge clk); rd(A_CNT, v); chk("R12 write beats decrement", v, 32'd50);
    rd(A_PER, v); chk("R8 period stored", v, 32'd50);
    step_cycle(); rd(A_CNT, v); chk("R8 continues from mirror", v, 32'd49);
    // R9 count write while running
    wr(A_CNT, 32'd20);
    @(negedge clk); rd(A_CNT, v); chk("R9 count write running", v, 32'd20);
    step_cycle(); rd(A_CNT, v); chk("R9 continues", v, 32'd19);

    // R11 scale change while running
    wr(A_CTRL, 32'h0);
    wr(A_CNT, 32'd100);
    wr(A_CTRL, 32'h3);
    wr(A_SCL, 32'd9);
    @(negedge clk); rd(A_CNT, v); chk("R11 old step on write edge", v, 32'd99);
    step_cycle(); rd(A_CNT, v); chk("R11 new step", v, 32'd89);
    step_cycle(); rd(A_CNT, v); chk("R11 new step again", v, 32'd79);

    // R6 auto-reload, period 7 step 2 -> every 4 clocks
    wr(A_CTRL, 32'h0);
    wr(A_SCL, 32'd1);
    wr(A_PER, 32'd7);
    @(negedge clk); rd(A_CNT, v); chk("R8 period mirrored", v, 32'd7);
    wr(A_CTRL, 32'h7);
    for (int r = 0; r < 3; r++) begin
      wait_irq(n);
      chk("R6 reload interval", 32'(n), 32'd4);
      rd(A_CNT, v); chk("R6 count reloaded", v, 32'd7);
      rd(A_CTRL, v); chk("R6 flag with reload", v, 32'hF);
    end
    // R10 clear flag while running
    wr(A_CTRL, 32'h7);
    @(negedge clk); rd(A_CTRL, v); chk("R10 flag cleared running", v, 32'h7);
    // R6 period 0 -> irq every clock
    wr(A_PER, 32'd0);
    @(negedge clk);
    extra = 0;
    for (int k = 0; k < 4; k++) begin step_cycle(); if (irq) extra++; end
    chk("R6 period zero irq each clock", 32'(extra), 32'd4);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule